// File: doc/BRIEF.md
# Run-Time Bit Position Load Unit

This unit fetches one bit from word-organised memory when the position of that bit is only known at run time. A request presents a byte-granular base pointer together with a bit offset counted from that pointer. The unit turns the offset into a byte displacement by dividing it by eight, adds it to the base, and drops the two lowest address bits so that the fetch lands on a 32-bit word boundary. It issues a single word read at that address and waits for the memory to answer.

When the read data returns, the unit picks one bit out of the word. The position it uses is the low five bits of the original offset, which are the bits that the address arithmetic threw away. The chosen bit goes to bit 0 of a 32-bit result whose other bits are zero, and a one-cycle done flag marks the completion. While a fetch is in flight the unit refuses new work: a start strobe seen in that time is dropped and does not disturb the captured operands.

The fetch proceeds through four phases: idle, address issue, waiting for read data, and completion. The memory side may take any number of cycles to answer; the unit only looks at the read-valid strobe while it is waiting.

Top module: `bitptr_load_unit`

## Requirements
- R1: After reset, rd_req_o and done_o are 0 and result_o is all zeros.
- R2: The read address equals (base_ptr_i + (bit_off_i >> 3)) computed modulo 2^32 with bits 1:0 then forced to 0, using the operands captured when the start was accepted.
- R3: A start_i seen while idle is accepted at that clock edge, and rd_req_o is high for exactly the one following cycle.
- R4: After the request the unit waits any number of cycles for rd_valid_i; done_o never rises before read data has been accepted.
- R5: On completion result_o[0] equals rd_data_i[bit_off_i[4:0]] sampled with the accepted rd_valid_i, and result_o[31:1] are 0.
- R6: done_o is high for exactly the one cycle after rd_valid_i is accepted, and result_o keeps its value until the next completion.
- R7: start_i is ignored from the acceptance edge until the unit is idle again: it raises no request and changes neither the address nor the result of the fetch in flight.
- R8: rd_valid_i is ignored unless the unit is waiting for read data (after its request cycle): outside that phase it neither completes a fetch nor changes result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a bit fetch with the present operands |
| base_ptr_i | input | 32 | Byte base pointer |
| bit_off_i | input | 32 | Bit offset from the base pointer |
| rd_req_o | output | 1 | One-cycle word read request |
| rd_addr_o | output | 32 | Word-aligned read address, valid with rd_req_o |
| rd_valid_i | input | 1 | Read data is present on rd_data_i |
| rd_data_i | input | 32 | Read data word |
| result_o | output | 32 | Extracted bit in bit 0, zero above |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Fetches are tried with aligned bases and small offsets, with unaligned bases whose offsets carry into the next word, with an all-ones offset that selects bit 31, and with a base near the top of the address space so that the sum wraps; together these separate a correct shift-add-mask from an unshifted add, a missing mask or a mask applied before the add. Data words are chosen so that the selected bit differs from its neighbours, which tells the right position from an off-by-one or from using high offset bits. Response latencies of zero to several cycles, a start held high through a whole fetch with changed operands, and read-valid pulses in the idle and address phases show that only the waiting phase reacts and that captured operands stay put.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } bpl_state_e;

   localparam int unsigned BITS_PER_BYTE_LOG2 = 3;

endpackage

// File: rtl/bpl_addr_gen.sv
module bpl_addr_gen #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] off_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int unsigned ALIGN_BITS = $clog2(DATA_W / 8);
   localparam logic [ADDR_W-1:0] ALIGN_MASK =
      {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

   logic [ADDR_W-1:0] byte_disp;
   logic [ADDR_W-1:0] raw_sum;

   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("bpl_addr_gen: ADDR_W too small");
      end
   endgenerate

   always_comb begin
      byte_disp = off_i >> bpl_pkg::BITS_PER_BYTE_LOG2;
      raw_sum   = base_i + byte_disp;
      addr_o    = raw_sum & ALIGN_MASK;
   end

endmodule

// File: rtl/bpl_bit_extract.sv
module bpl_bit_extract #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STYLE  = 0,
   localparam int unsigned SEL_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [DATA_W-1:0] result_o
);
   logic picked;

   generate
      if (STYLE == 0) begin : g_mux
         always_comb picked = word_i[sel_i];
      end else if (STYLE == 1) begin : g_shift
         logic [DATA_W-1:0] shifted;
         always_comb begin
            shifted = word_i >> sel_i;
            picked  = shifted[0];
         end
      end else begin : g_bad_style
         $error("bpl_bit_extract: STYLE must be 0 or 1");
         always_comb picked = 1'b0;
      end
   endgenerate

   always_comb result_o = {{(DATA_W-1){1'b0}}, picked};

endmodule

// File: rtl/bpl_seq.sv
module bpl_seq (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                rd_valid_i,
   output logic                accept_o,
   output logic                capture_o,
   output logic                rd_req_o,
   output logic                done_o,
   output bpl_pkg::bpl_state_e state_o
);
   import bpl_pkg::*;

   bpl_state_e state_q, state_d;

   always_comb begin
      state_d   = state_q;
      accept_o  = 1'b0;
      capture_o = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            accept_o = 1'b1;
            state_d  = ST_ADDR;
         end
         ST_ADDR: state_d = ST_WAIT;
         ST_WAIT: if (rd_valid_i) begin
            capture_o = 1'b1;
            state_d   = ST_DONE;
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign rd_req_o = (state_q == ST_ADDR);
   assign done_o   = (state_q == ST_DONE);
   assign state_o  = state_q;

   AST_REQ_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && start_i) |=> rd_req_o); // R3
   AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req_o |=> !rd_req_o); // R3
   AST_BUSY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE) |=> !rd_req_o); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R6

endmodule

// File: rtl/bitptr_load_unit.sv
module bitptr_load_unit #(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned EXTRACT_STYLE = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_ptr_i,
   input  logic [ADDR_W-1:0] bit_off_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] result_o,
   output logic              done_o
);
   localparam int unsigned SEL_W = $clog2(DATA_W);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("bitptr_load_unit: DATA_W must be a power of two of at least 8");
      end
      if (SEL_W > ADDR_W) begin : g_bad_sel
         $error("bitptr_load_unit: offset narrower than bit select");
      end
   endgenerate

   logic                accept, capture;
   bpl_pkg::bpl_state_e state;
   logic [ADDR_W-1:0]   base_q, off_q;
   logic [DATA_W-1:0]   result_q, extracted;

   bpl_seq u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .rd_valid_i (rd_valid_i),
      .accept_o   (accept),
      .capture_o  (capture),
      .rd_req_o   (rd_req_o),
      .done_o     (done_o),
      .state_o    (state)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         off_q  <= '0;
      end else if (accept) begin
         base_q <= base_ptr_i;
         off_q  <= bit_off_i;
      end
   end

   bpl_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
      .base_i (base_q),
      .off_i  (off_q),
      .addr_o (rd_addr_o)
   );

   bpl_bit_extract #(.DATA_W(DATA_W), .STYLE(EXTRACT_STYLE)) u_extract (
      .word_i   (rd_data_i),
      .sel_i    (off_q[SEL_W-1:0]),
      .result_o (extracted)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      result_q <= '0;
      else if (capture) result_q <= extracted;
   end

   assign result_o = result_q;

   AST_DONE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> $past(rd_valid_i)); // R4
   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o)); // R6
   AST_OPERANDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != bpl_pkg::ST_IDLE) |=> $stable(rd_addr_o)); // R7
   AST_VALID_OUTSIDE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state != bpl_pkg::ST_WAIT && rd_valid_i) |=> !done_o); // R8

endmodule

// File: tb/bitptr_load_unit_tb_top.sv
module bitptr_load_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [31:0] off = '0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_data = '0;
   logic [31:0] result;
   logic        done;

   int checks = 0;
   int errors = 0;
   logic [31:0] held = '0;

   always #4 clk = ~clk;

   bitptr_load_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .base_ptr_i(base), .bit_off_i(off),
      .rd_req_o(rd_req), .rd_addr_o(rd_addr),
      .rd_valid_i(rd_valid), .rd_data_i(rd_data),
      .result_o(result), .done_o(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] ref_addr(input logic [31:0] b, input logic [31:0] o);
      logic [31:0] s;
      s = b + (o / 8);
      return s - (s % 4);
   endfunction

   function automatic logic [31:0] ref_result(input logic [31:0] d, input logic [31:0] o);
      int pos;
      pos = int'(o % 32);
      return {31'd0, d[pos]};
   endfunction

   task automatic do_load(input logic [31:0] b, input logic [31:0] o, input logic [31:0] d,
                          input int lat, input bit hold_start, input bit early_valid);
      logic [31:0] exp_res;
      exp_res = ref_result(d, o);
      @(negedge clk);
      start = 1'b1; base = b; off = o;
      check("R3 idle no req", {31'd0, rd_req}, 32'd0);
      check("R6 idle no done", {31'd0, done}, 32'd0);
      @(negedge clk);
      if (hold_start) begin base = ~b; off = o ^ 32'h0000_0055; end
      else start = 1'b0;
      if (early_valid) begin rd_valid = 1'b1; rd_data = ~d; end
      check("R3 req pulse", {31'd0, rd_req}, 32'd1);
      check("R2 address", rd_addr, ref_addr(b, o));
      check("R4 no early done", {31'd0, done}, 32'd0);
      for (int i = 0; i <= lat; i++) begin
         @(negedge clk);
         check("R7 no second req", {31'd0, rd_req}, 32'd0);
         check("R4 waiting no done", {31'd0, done}, 32'd0);
         check("R6 result held while busy", result, held);
         if (i == lat) begin
            rd_valid = 1'b1; rd_data = d; start = 1'b0;
         end else begin
            rd_valid = 1'b0; rd_data = ~d;
         end
      end
      @(negedge clk);
      rd_valid = 1'b0; rd_data = ~d;
      check("R6 done pulse", {31'd0, done}, 32'd1);
      check("R5 extracted bit", result, exp_res);
      @(negedge clk);
      check("R6 done single", {31'd0, done}, 32'd0);
      check("R7 no relaunch", {31'd0, rd_req}, 32'd0);
      check("R6 result kept", result, exp_res);
      held = exp_res;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset req", {31'd0, rd_req}, 32'd0);
      check("R1 reset done", {31'd0, done}, 32'd0);
      check("R1 reset result", result, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release result", result, 32'd0);

      do_load(32'h0000_1000, 32'd0,          32'h0000_0001, 0, 1'b0, 1'b0);
      do_load(32'h0000_1000, 32'd0,          32'hFFFF_FFFE, 2, 1'b0, 1'b0);
      do_load(32'h0000_1003, 32'h0000_000D,  32'h0000_2000, 1, 1'b0, 1'b0);
      do_load(32'h0000_2000, 32'h0000_0127,  32'h0000_0080, 3, 1'b0, 1'b0);
      do_load(32'h0000_0100, 32'hFFFF_FFFF,  32'h8000_0000, 0, 1'b0, 1'b0);
      do_load(32'hFFFF_FFFE, 32'h0000_0040,  32'hFFFF_FFFF, 4, 1'b0, 1'b0);
      do_load(32'h0000_3000, 32'h0000_0032,  32'h0004_0000, 2, 1'b1, 1'b0);
      do_load(32'h0000_4004, 32'h0000_0009,  32'hFFFF_FDFF, 0, 1'b1, 1'b1);
      do_load(32'h0000_5000, 32'h0000_0015,  32'h0020_0000, 0, 1'b0, 1'b1);

      @(negedge clk);
      rd_valid = 1'b1; rd_data = 32'h0000_0000;
      @(negedge clk);
      rd_valid = 1'b0;
      check("R8 idle valid no done", {31'd0, done}, 32'd0);
      check("R8 idle valid result", result, held);
      @(negedge clk);
      check("R8 idle valid still no done", {31'd0, done}, 32'd0);

      do_load(32'h0000_6000, 32'h0000_003E,  32'h4000_0000, 1, 1'b0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule